// File: doc/BRIEF.md
# Video Status and Beam Position Latch

This block answers CPU reads of three registers in a video controller: a status byte and two beam-position bytes. It watches a frame-position counter and a line-position counter supplied by an external timing generator, a single-cycle interrupt request from the sound unit, and the tracking bit of the video control register. The status byte reports the line and frame blanking conditions, whether a sound interrupt is pending, and the state of the tracking bit. Reading the status byte acknowledges the sound interrupt.

The position reads depend on the tracking bit. When it is set, a read captures the live beam position into a latch and returns it. The horizontal value is the line counter scaled by twelve. The vertical value is the frame counter divided by twenty-two, and it saturates to 0xFF past the last visible row. When the tracking bit is clear, a read returns the value captured earlier and leaves the latch unchanged. This lets software freeze a beam position and read it back later.

A read is one cycle of `rd_en` with a register select. The answer appears on `rd_data` after the clock edge that samples the request, and it stays there until the next read.

Top module: `vsp_beam_latch`

## Requirements
- R1: After reset, `rd_data`, both position latches and the pending sound interrupt are zero. A position read with `ctrl_trk`=0 right after reset returns 0x00.
- R2: Select encoding is `rd_sel` 2'b00 status, 2'b01 horizontal position, 2'b10 vertical position, 2'b11 reads 0x00. `rd_data` takes the value at the clock edge that samples `rd_en`=1 and holds while `rd_en` is 0.
- R3: Status bit 1 equals `ctrl_trk` at the read, and status bits 7..4 read as zero.
- R4: Status bit 3 is 1 when `frame_pos` is greater than parameter `VBL_TH` (default 5000), otherwise 0.
- R5: Status bit 0 is 1 when `line_pos` is less than `LINE_LEN`-7 (default 221), otherwise 0.
- R6: Status bit 2 reports a pending sound interrupt, which a `snd_irq` pulse sets. A status read returns the pending state and then clears it.
- R7: A `snd_irq` pulse in the same cycle as a status read stays pending. That read shows the earlier state, and the next status read shows bit 2 set.
- R8: With `ctrl_trk`=1, a horizontal read loads the horizontal latch with the low 8 bits of `line_pos`*12 and returns that value.
- R9: With `ctrl_trk`=1, a vertical read loads the vertical latch with `frame_pos`/22 (integer quotient), or with 0xFF when the quotient exceeds 241, and returns that value.
- R10: With `ctrl_trk`=0, a position read returns the held latch value and does not change it, whatever the counters show.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_pos | input | LINE_W | Line-position counter from the timing generator |
| frame_pos | input | FRAME_W | Frame-position counter from the timing generator |
| snd_irq | input | 1 | Single-cycle sound interrupt request |
| ctrl_trk | input | 1 | Tracking bit of the video control register |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_sel | input | 2 | Register select |
| rd_data | output | 8 | Read result, registered |

## Verification
The assertions assume that `rd_en` and `rd_sel` are steady over each clock cycle and that `snd_irq` is a clean level sampled at the edge. They do not assume that the counters stay in any range. The stimulus changes every input only at the falling clock edge. It holds each request for exactly one cycle and drops `rd_en` before the result is sampled, so every hold property sees idle cycles between accesses.

// File: rtl/vsp_pkg.sv
package vsp_pkg;
    typedef enum logic [1:0] {
        SEL_STATUS = 2'b00,
        SEL_HPOS   = 2'b01,
        SEL_VPOS   = 2'b10,
        SEL_NONE   = 2'b11
    } rd_sel_e;

    localparam int BIT_LINE_ACT = 0;
    localparam int BIT_TRK      = 1;
    localparam int BIT_IRQ      = 2;
    localparam int BIT_VBLANK   = 3;

    localparam int POS_HORIZ = 0;
    localparam int POS_VERT  = 1;
endpackage

// File: rtl/vsp_status.sv
module vsp_status #(
    parameter int LINE_W   = 8,
    parameter int FRAME_W  = 13,
    parameter int LINE_LEN = 228,
    parameter int VBL_TH   = 5000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINE_W-1:0]  line_pos,
    input  logic [FRAME_W-1:0] frame_pos,
    input  logic               ctrl_trk,
    input  logic               snd_irq,
    input  logic               stat_rd,
    output logic [7:0]         status,
    output logic               irq_pend
);
    import vsp_pkg::*;

    localparam logic [LINE_W-1:0]  LINE_LIMIT = LINE_W'(LINE_LEN - 7);
    localparam logic [FRAME_W-1:0] VBL_LIMIT  = FRAME_W'(VBL_TH);

    typedef struct packed {
        logic pend;
    } stat_state_t;

    stat_state_t st_d, st_q;

    always_comb begin
        status = 8'h00;
        status[BIT_LINE_ACT] = (line_pos < LINE_LIMIT);
        status[BIT_TRK]      = ctrl_trk;
        status[BIT_IRQ]      = st_q.pend;
        status[BIT_VBLANK]   = (frame_pos > VBL_LIMIT);

        st_d      = st_q;
        // a new request wins over the acknowledge of the same cycle
        st_d.pend = snd_irq | (st_q.pend & ~stat_rd);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_pend = st_q.pend;

    p_irq_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !snd_irq) |=> !irq_pend);

    p_irq_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        snd_irq |=> irq_pend);

    p_irq_persists_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend && !stat_rd) |=> irq_pend);
endmodule

// File: rtl/vsp_pos_latch.sv
module vsp_pos_latch #(
    parameter int IN_W    = 8,
    parameter int MODE    = 0,
    parameter int SCALE   = 12,
    parameter int DIV     = 22,
    parameter int SAT_MAX = 241
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IN_W-1:0] pos_in,
    input  logic            load,
    output logic [7:0]      sample,
    output logic [7:0]      held
);
    import vsp_pkg::*;

    typedef struct packed {
        logic [7:0] val;
    } pos_state_t;

    pos_state_t ps_d, ps_q;

    generate
        if (MODE == POS_HORIZ) begin : g_horiz
            localparam int PW = IN_W + 8;
            logic [PW-1:0] prod;
            always_comb begin
                prod   = PW'(pos_in) * PW'(SCALE);
                sample = prod[7:0];
            end
        end else begin : g_vert
            logic [IN_W-1:0] quot;
            always_comb begin
                quot = pos_in / IN_W'(DIV);
                if (quot > IN_W'(SAT_MAX)) sample = 8'hFF;
                else                       sample = 8'(quot);
            end
            p_vert_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (held <= 8'(SAT_MAX)) || (held == 8'hFF));
        end
    endgenerate

    always_comb begin
        ps_d = ps_q;
        if (load) ps_d.val = sample;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end

    assign held = ps_q.val;

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(held));
endmodule

// File: rtl/vsp_beam_latch.sv
module vsp_beam_latch #(
    parameter int LINE_W   = 8,
    parameter int FRAME_W  = 13,
    parameter int LINE_LEN = 228,
    parameter int VBL_TH   = 5000,
    parameter int H_SCALE  = 12,
    parameter int V_DIV    = 22,
    parameter int V_MAX    = 241
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINE_W-1:0]  line_pos,
    input  logic [FRAME_W-1:0] frame_pos,
    input  logic               snd_irq,
    input  logic               ctrl_trk,
    input  logic               rd_en,
    input  logic [1:0]         rd_sel,
    output logic [7:0]         rd_data
);
    import vsp_pkg::*;

    typedef struct packed {
        logic [7:0] data;
    } top_state_t;

    top_state_t ts_d, ts_q;
    rd_sel_e    sel;
    logic       stat_rd, h_load, v_load, irq_pend;
    logic [7:0] status, h_samp, h_held, v_samp, v_held;

    assign sel     = rd_sel_e'(rd_sel);
    assign stat_rd = rd_en && (sel == SEL_STATUS);
    assign h_load  = rd_en && (sel == SEL_HPOS) && ctrl_trk;
    assign v_load  = rd_en && (sel == SEL_VPOS) && ctrl_trk;

    vsp_status #(
        .LINE_W(LINE_W), .FRAME_W(FRAME_W),
        .LINE_LEN(LINE_LEN), .VBL_TH(VBL_TH)
    ) u_status (
        .clk(clk), .rst_n(rst_n), .line_pos(line_pos), .frame_pos(frame_pos),
        .ctrl_trk(ctrl_trk), .snd_irq(snd_irq), .stat_rd(stat_rd),
        .status(status), .irq_pend(irq_pend)
    );

    vsp_pos_latch #(
        .IN_W(LINE_W), .MODE(POS_HORIZ), .SCALE(H_SCALE),
        .DIV(V_DIV), .SAT_MAX(V_MAX)
    ) u_hpos (
        .clk(clk), .rst_n(rst_n), .pos_in(line_pos), .load(h_load),
        .sample(h_samp), .held(h_held)
    );

    vsp_pos_latch #(
        .IN_W(FRAME_W), .MODE(POS_VERT), .SCALE(H_SCALE),
        .DIV(V_DIV), .SAT_MAX(V_MAX)
    ) u_vpos (
        .clk(clk), .rst_n(rst_n), .pos_in(frame_pos), .load(v_load),
        .sample(v_samp), .held(v_held)
    );

    always_comb begin
        ts_d = ts_q;
        if (rd_en) begin
            unique case (sel)
                SEL_STATUS: ts_d.data = status;
                SEL_HPOS:   ts_d.data = ctrl_trk ? h_samp : h_held;
                SEL_VPOS:   ts_d.data = ctrl_trk ? v_samp : v_held;
                default:    ts_d.data = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_d;
    end

    assign rd_data = ts_q.data;

    p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    p_unused_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == 2'b11) |=> (rd_data == 8'h00));

    p_hread_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == 2'b01) |=> (rd_data == h_held));

    p_vread_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == 2'b10) |=> (rd_data == v_held));

    p_status_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == 2'b00) |=> (rd_data[7:4] == 4'h0));
endmodule

// File: tb/vsp_beam_latch_bench.sv
module vsp_beam_latch_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_W     = 8;
    localparam int FRAME_W    = 13;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [LINE_W-1:0]  line_pos = '0;
    logic [FRAME_W-1:0] frame_pos = '0;
    logic               snd_irq = 1'b0;
    logic               ctrl_trk = 1'b0;
    logic               rd_en = 1'b0;
    logic [1:0]         rd_sel = 2'b00;
    logic [7:0]         rd_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vsp_beam_latch u_vsp_beam_latch (
        .clk(clk), .rst_n(rst_n), .line_pos(line_pos), .frame_pos(frame_pos),
        .snd_irq(snd_irq), .ctrl_trk(ctrl_trk), .rd_en(rd_en),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [1:0] sel, input logic irq, output logic [7:0] val);
        @(negedge clk);
        rd_en = 1'b1; rd_sel = sel; snd_irq = irq;
        @(negedge clk);
        rd_en = 1'b0; snd_irq = 1'b0;
        val = rd_data;
    endtask

    function automatic logic [7:0] exp_h(input int ln);
        return 8'((ln * 12) % 256);
    endfunction

    function automatic logic [7:0] exp_v(input int fr);
        int q = fr / 22;
        return (q > 241) ? 8'hFF : 8'(q);
    endfunction

    function automatic logic [7:0] exp_stat(input int ln, input int fr,
                                            input logic trk, input logic irq);
        logic [7:0] s = 8'h00;
        s[0] = (ln < 221);
        s[1] = trk;
        s[2] = irq;
        s[3] = (fr > 5000);
        return s;
    endfunction

    task automatic t_reset;
        logic [7:0] v;
        chk("R1 rd_data after reset", rd_data, 8'h00);
        ctrl_trk = 1'b0; line_pos = 8'd100; frame_pos = 13'd3000;
        do_read(2'b01, 1'b0, v); chk("R1 hpos latch reset", v, 8'h00);
        do_read(2'b10, 1'b0, v); chk("R1 vpos latch reset", v, 8'h00);
        line_pos = 8'd250; frame_pos = 13'd0;
        do_read(2'b00, 1'b0, v); chk("R1 status after reset", v, 8'h00);
    endtask

    task automatic t_status;
        logic [7:0] v;
        ctrl_trk = 1'b1; line_pos = 8'd10; frame_pos = 13'd6000;
        do_read(2'b00, 1'b0, v); chk("R3 R4 R5 status mix", v, exp_stat(10, 6000, 1'b1, 1'b0));
        line_pos = 8'd220; frame_pos = 13'd5000; ctrl_trk = 1'b0;
        do_read(2'b00, 1'b0, v); chk("R5 line 220 R4 frame 5000", v, exp_stat(220, 5000, 1'b0, 1'b0));
        line_pos = 8'd221; frame_pos = 13'd5001;
        do_read(2'b00, 1'b0, v); chk("R5 line 221 R4 frame 5001", v, exp_stat(221, 5001, 1'b0, 1'b0));
    endtask

    task automatic t_irq;
        logic [7:0] v;
        line_pos = 8'd221; frame_pos = 13'd0; ctrl_trk = 1'b0;
        @(negedge clk); snd_irq = 1'b1;
        @(negedge clk); snd_irq = 1'b0;
        repeat (3) @(negedge clk);
        do_read(2'b00, 1'b0, v); chk("R6 pending shown", v, 8'h04);
        do_read(2'b00, 1'b0, v); chk("R6 cleared by read", v, 8'h00);
        do_read(2'b00, 1'b1, v); chk("R7 coincident read shows old", v, 8'h00);
        do_read(2'b00, 1'b0, v); chk("R7 coincident irq kept", v, 8'h04);
        do_read(2'b00, 1'b0, v); chk("R7 then cleared", v, 8'h00);
    endtask

    task automatic t_track;
        logic [7:0] v;
        ctrl_trk = 1'b1;
        line_pos = 8'd20; do_read(2'b01, 1'b0, v); chk("R8 hpos 20", v, exp_h(20));
        line_pos = 8'd22; do_read(2'b01, 1'b0, v); chk("R8 hpos wrap 22", v, exp_h(22));
        frame_pos = 13'd5302; do_read(2'b10, 1'b0, v); chk("R9 vpos 241", v, exp_v(5302));
        frame_pos = 13'd21;   do_read(2'b10, 1'b0, v); chk("R9 vpos 0", v, exp_v(21));
        frame_pos = 13'd5324; do_read(2'b10, 1'b0, v); chk("R9 vpos saturate", v, exp_v(5324));
        frame_pos = 13'd1000; do_read(2'b10, 1'b0, v); chk("R9 vpos mid", v, exp_v(1000));
    endtask

    task automatic t_hold;
        logic [7:0] v;
        ctrl_trk = 1'b0; line_pos = 8'd77; frame_pos = 13'd7000;
        do_read(2'b01, 1'b0, v); chk("R10 hpos held", v, exp_h(22));
        do_read(2'b10, 1'b0, v); chk("R10 vpos held", v, exp_v(1000));
        ctrl_trk = 1'b1; line_pos = 8'd5;
        do_read(2'b01, 1'b0, v); chk("R10 retrack hpos", v, exp_h(5));
        ctrl_trk = 1'b0; line_pos = 8'd200;
        do_read(2'b01, 1'b0, v); chk("R10 hold new value", v, exp_h(5));
    endtask

    task automatic t_select;
        logic [7:0] v;
        ctrl_trk = 1'b1; line_pos = 8'd3;
        do_read(2'b11, 1'b0, v); chk("R2 unused select", v, 8'h00);
        do_read(2'b01, 1'b0, v); chk("R2 hpos value", v, exp_h(3));
        line_pos = 8'd9; frame_pos = 13'd8000;
        repeat (4) @(negedge clk);
        chk("R2 rd_data held while idle", rd_data, exp_h(3));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_status();
        t_irq();
        t_track();
        t_hold();
        t_select();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule